// File: doc/BRIEF.md
# Overlapping Register Window File

This block holds the general-purpose registers of a 32-bit load/store processor and presents them through a sliding window. Instructions name 32 logical registers with 5-bit numbers; a 3-bit current-window pointer steers each logical number to one of 138 physical 32-bit registers. Ten logical registers are common to every window. The remaining 22 belong to the current window: six incoming, ten private, and six outgoing.

A procedure call moves the pointer one window forward and a return moves it one window back. The outgoing six of one window are the same physical storage as the incoming six of the next. Parameters and results therefore cross a call boundary without any register being copied.

A count of resident windows guards the finite storage. A call that would exceed seven resident windows, or a return from the last resident window, leaves the pointer where it is and raises a flag. An external trap handler then spills or refills memory. The block has two combinational read ports and one clocked write port with write-through forwarding.

Top module: `regwin_file`

## Requirements
- R1: While `rst` is high at a clock edge, the window pointer becomes 0 and the resident count becomes 1, so a return presented immediately after reset reports underflow.
- R2: Logical registers 0 to 9 map to the same ten physical registers in every window. A value written there is read back unchanged after any calls or returns.
- R3: A call (`call_i` high, `ret_i` low) presented while seven windows are resident drives `overflow_o` high in that same cycle, and `cwp_o` keeps its value after the edge.
- R4: A return (`ret_i` high, `call_i` low) presented while one window is resident drives `underflow_o` high in that same cycle, and `cwp_o` keeps its value after the edge.
- R5: An accepted call adds one to `cwp_o` modulo 8. The callee's logical register 10+k (k = 0..5) then reads the value the caller held in logical register 26+k.
- R6: An accepted return subtracts one from `cwp_o` modulo 8. The caller's logical register 26+k then reads what the callee last wrote to its logical register 10+k.
- R7: Logical registers 16 to 25 are private to a window. A write to one of them in the callee leaves the caller's register of the same number unchanged.
- R8: When the write enable is high and a read address equals the write address, that read port returns the write data in the same cycle.
- R9: When `call_i` and `ret_i` are both high, neither flag is raised and `cwp_o` keeps its value.
- R10: A write presented in the same cycle as a call or return goes to the window that was current before the pointer moved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Data to write |
| rd_addr_a | input | 5 | Logical register for read port A |
| rd_data_a | output | 32 | Read data, port A |
| rd_addr_b | input | 5 | Logical register for read port B |
| rd_data_b | output | 32 | Read data, port B |
| cwp_o | output | 3 | Current window pointer |
| overflow_o | output | 1 | Call refused, no free window |
| underflow_o | output | 1 | Return refused, last resident window |

## Verification
Read data and both flags are combinational, so they are due in the same cycle as the addresses and the call or return request. The bench compares them a short settling delay after it drives inputs on the falling edge, which is well before the next rising edge. The pointer and the stored registers change one rising edge after the request. The bench advances its own model of the pointer, the resident count and the physical array at that edge, so every later compare uses the post-edge state. Corner cases are run as directed steps before a seeded random phase: window exhaustion in both directions, simultaneous call and return, and a write on the same cycle as a pointer move.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int DATA_W   = 32;
    localparam int NWIN     = 8;
    localparam int NGLOB    = 10;
    localparam int NIN      = 6;
    localparam int NLOC     = 10;
    localparam int NOUT     = NIN;
    localparam int LREG     = NGLOB + NIN + NLOC + NOUT;
    localparam int LA_W     = $clog2(LREG);
    localparam int WP_W     = $clog2(NWIN);
    localparam int WIN_SPAN = NIN + NLOC;
    localparam int NPHYS    = NGLOB + NWIN * WIN_SPAN;
    localparam int PA_W     = $clog2(NPHYS);
    localparam int CNT_W    = $clog2(NWIN + 1);
    localparam int IN_BASE  = NGLOB;
    localparam int LOC_BASE = IN_BASE + NIN;
    localparam int OUT_BASE = LOC_BASE + NLOC;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [LA_W-1:0]   laddr_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [WP_W-1:0]   wptr_t;
    typedef logic [CNT_W-1:0]  wcnt_t;

    typedef enum logic [1:0] {
        RC_GLOBAL,
        RC_IN,
        RC_LOCAL,
        RC_OUT
    } rclass_e;

    typedef struct packed {
        rclass_e cls;
        laddr_t  off;
    } rdec_t;

    function automatic rdec_t classify(input laddr_t r);
        rdec_t d;
        if (int'(r) < IN_BASE) begin
            d.cls = RC_GLOBAL;
            d.off = r;
        end else if (int'(r) < LOC_BASE) begin
            d.cls = RC_IN;
            d.off = laddr_t'(int'(r) - IN_BASE);
        end else if (int'(r) < OUT_BASE) begin
            d.cls = RC_LOCAL;
            d.off = laddr_t'(int'(r) - LOC_BASE);
        end else begin
            d.cls = RC_OUT;
            d.off = laddr_t'(int'(r) - OUT_BASE);
        end
        return d;
    endfunction

    // Window w owns a block of WIN_SPAN registers: incoming first, then locals.
    // Outgoing registers alias the incoming block of window w+1.
    function automatic paddr_t window_base(input wptr_t w);
        return paddr_t'(NGLOB + int'(w) * WIN_SPAN);
    endfunction

    function automatic paddr_t to_phys(input laddr_t r, input wptr_t w);
        rdec_t  d;
        paddr_t p;
        d = classify(r);
        unique case (d.cls)
            RC_GLOBAL: p = paddr_t'(d.off);
            RC_IN:     p = window_base(w) + paddr_t'(d.off);
            RC_LOCAL:  p = window_base(w) + paddr_t'(NIN) + paddr_t'(d.off);
            default:   p = window_base(w + wptr_t'(1)) + paddr_t'(d.off);
        endcase
        return p;
    endfunction
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  call_req,
    input  logic  ret_req,
    output wptr_t cwp,
    output logic  ovf,
    output logic  unf
);
    localparam wcnt_t MAX_RES = wcnt_t'(NWIN - 1);

    wptr_t cwp_q;
    wcnt_t res_q;
    logic  call_only, ret_only, full, last;

    assign call_only = call_req & ~ret_req;
    assign ret_only  = ret_req & ~call_req;
    assign full      = (res_q == MAX_RES);
    assign last      = (res_q == wcnt_t'(1));
    assign ovf       = call_only & full;
    assign unf       = ret_only & last;
    assign cwp       = cwp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            res_q <= wcnt_t'(1);
        end else if (call_only && !full) begin
            cwp_q <= cwp_q + wptr_t'(1);
            res_q <= res_q + wcnt_t'(1);
        end else if (ret_only && !last) begin
            cwp_q <= cwp_q - wptr_t'(1);
            res_q <= res_q - wcnt_t'(1);
        end
    end
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  wptr_t  cwp,
    input  laddr_t la [NPORT],
    output paddr_t pa [NPORT]
);
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign pa[i] = to_phys(la[i], cwp);
    end
endmodule

// File: rtl/regwin_array.sv
module regwin_array
    import regwin_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic   clk,
    input  logic   we,
    input  paddr_t wpa,
    input  data_t  wd,
    input  paddr_t rpa [NRD],
    output data_t  rd  [NRD]
);
    data_t mem [NPHYS];

    always_ff @(posedge clk) begin
        if (we) mem[wpa] <= wd;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rd[i] = (we && (wpa == rpa[i])) ? wd : mem[rpa[i]];
    end
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              wr_en,
    input  logic [LA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LA_W-1:0]   rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [LA_W-1:0]   rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [WP_W-1:0]   cwp_o,
    output logic              overflow_o,
    output logic              underflow_o
);
    localparam int NRD = 2;
    localparam int NXP = NRD + 1;

    wptr_t  cwp;
    laddr_t la [NXP];
    paddr_t pa [NXP];
    paddr_t rpa [NRD];
    data_t  rd [NRD];

    regwin_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .call_req (call_i),
        .ret_req  (ret_i),
        .cwp      (cwp),
        .ovf      (overflow_o),
        .unf      (underflow_o)
    );

    assign la[0] = rd_addr_a;
    assign la[1] = rd_addr_b;
    assign la[2] = wr_addr;

    regwin_xlate #(.NPORT(NXP)) u_xlate (
        .cwp (cwp),
        .la  (la),
        .pa  (pa)
    );

    for (genvar i = 0; i < NRD; i++) begin : g_rpa
        assign rpa[i] = pa[i];
    end

    regwin_array #(.NRD(NRD)) u_array (
        .clk (clk),
        .we  (wr_en),
        .wpa (pa[NRD]),
        .wd  (wr_data),
        .rpa (rpa),
        .rd  (rd)
    );

    assign rd_data_a = rd[0];
    assign rd_data_b = rd[1];
    assign cwp_o     = cwp;
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk
    import regwin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              call_i,
    input logic              ret_i,
    input logic              wr_en,
    input logic [LA_W-1:0]   wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LA_W-1:0]   rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [LA_W-1:0]   rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [WP_W-1:0]   cwp_o,
    input logic              overflow_o,
    input logic              underflow_o
);
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> cwp_o == '0);

    p_no_overflow_move_r3: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> $stable(cwp_o));

    p_no_underflow_move_r4: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> $stable(cwp_o));

    p_call_step_r5: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && !overflow_o) |=> cwp_o == WP_W'($past(cwp_o) + 1'b1));

    p_ret_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !underflow_o) |=> cwp_o == WP_W'($past(cwp_o) - 1'b1));

    p_bypass_a_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == rd_addr_a) |-> rd_data_a == wr_data);

    p_bypass_b_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == rd_addr_b) |-> rd_data_b == wr_data);

    p_both_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |-> !overflow_o && !underflow_o);

    p_both_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i) |=> $stable(cwp_o));

    p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(overflow_o && underflow_o));
endmodule

bind regwin_file regwin_file_chk u_chk (.*);

// File: tb/regwin_file_test.sv
module regwin_file_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic [2:0]  cwp_o;
    logic        overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;

    int          m_cwp, m_res;
    logic [31:0] m_mem [138];
    bit          m_val [138];

    always #4 clk = ~clk;

    regwin_file uut (.*);

    // Requirement mapping: globals 0-9, incoming 10-15, locals 16-25,
    // outgoing 26-31 aliasing the incoming block of the next window.
    function automatic int bmap(int r, int w);
        if (r < 10) return r;
        if (r < 16) return 10 + 16 * w + (r - 10);
        if (r < 26) return 16 * w + r;
        return 10 + 16 * ((w + 1) % 8) + (r - 26);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit c, bit r, bit we, int wa, logic [31:0] wd,
                        int ra, int rb);
        int pw, pa_a, pa_b;
        bit e_ovf, e_unf;
        @(negedge clk);
        call_i = c; ret_i = r; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd; rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        #2;
        pw = bmap(wa, m_cwp);
        pa_a = bmap(ra, m_cwp);
        pa_b = bmap(rb, m_cwp);
        e_ovf = c && !r && (m_res == 7);
        e_unf = r && !c && (m_res == 1);
        chk(tag, "cwp", 32'(cwp_o), 32'(m_cwp));
        chk(tag, "overflow", 32'(overflow_o), 32'(e_ovf));
        chk(tag, "underflow", 32'(underflow_o), 32'(e_unf));
        if (we && pw == pa_a) chk(tag, "rd_a bypass", rd_data_a, wd);
        else if (m_val[pa_a]) chk(tag, "rd_a", rd_data_a, m_mem[pa_a]);
        if (we && pw == pa_b) chk(tag, "rd_b bypass", rd_data_b, wd);
        else if (m_val[pa_b]) chk(tag, "rd_b", rd_data_b, m_mem[pa_b]);
        @(posedge clk);
        if (we) begin m_mem[pw] = wd; m_val[pw] = 1'b1; end
        if (c && !r && m_res < 7) begin m_cwp = (m_cwp + 1) % 8; m_res++; end
        else if (r && !c && m_res > 1) begin m_cwp = (m_cwp + 7) % 8; m_res--; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < 138; i++) m_val[i] = 1'b0;
        m_cwp = 0; m_res = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, a return right away underflows (also R4)
        step("R1", 0, 1, 0, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0, 0, 0);
        // R2 global, R7 local, R5 outgoing in window 0
        step("R2", 0, 0, 1, 3, 32'hA0A0_0003, 3, 3);
        step("R7", 0, 0, 1, 20, 32'hB0B0_0020, 20, 3);
        step("R5", 0, 0, 1, 28, 32'hC0C0_0028, 28, 20);
        // R10: write local 16 during the call lands in window 0
        step("R10", 1, 0, 1, 16, 32'hD0D0_0016, 16, 28);
        // R5: callee incoming 12 shows caller outgoing 28; R2 global visible
        step("R5", 0, 0, 0, 0, 0, 12, 3);
        step("R7", 0, 0, 1, 20, 32'hE0E0_0020, 20, 16);
        step("R6", 0, 0, 1, 10, 32'hF0F0_0010, 10, 12);
        step("R6", 0, 1, 0, 0, 0, 26, 20);
        // back in window 0: 26 holds callee result, 20 unchanged, 16 from R10
        step("R6", 0, 0, 0, 0, 0, 26, 20);
        step("R10", 0, 0, 0, 0, 0, 16, 3);
        // R8 bypass on both ports
        step("R8", 0, 0, 1, 5, 32'h1234_5678, 5, 5);
        step("R8", 0, 0, 1, 27, 32'h8765_4321, 27, 5);
        // R9 simultaneous call and return
        step("R9", 1, 1, 0, 0, 0, 27, 5);
        step("R9", 0, 0, 0, 0, 0, 27, 5);
        // R3: six calls, then the seventh overflows
        for (int k = 0; k < 6; k++) step("R5", 1, 0, 1, 26, 32'(k + 100), 26, 10);
        step("R3", 1, 0, 0, 0, 0, 10, 3);
        step("R3", 0, 0, 0, 0, 0, 10, 3);
        for (int k = 0; k < 6; k++) step("R6", 0, 1, 0, 0, 0, 26, 3);
        step("R4", 0, 1, 0, 0, 0, 26, 3);
        step("R2", 0, 0, 0, 0, 0, 3, 5);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int sel;
            bit c, r;
            sel = int'($urandom_range(0, 15));
            c = (sel < 3) || (sel == 15);
            r = (sel >= 3 && sel < 6) || (sel == 15);
            step("R5/R6", c, r, 1'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
                 $urandom, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule